// File: doc/BRIEF.md
# Preemptive Priority Interrupt Controller

This block gathers level-sensitive interrupt requests from a set of hardware sources and presents a single interrupt line to a processor. Each source is given a 4-bit priority. Value 0 keeps the source silent at all times. Values 1 to 15 rank it, with 15 the most urgent. The controller names the winning source and tracks the level of the handler that is currently running. Only a request ranked strictly above that level can interrupt it.

The processor takes an interrupt by pulsing the acknowledge input. This records the winner's level as the new running level, and the earlier level is kept underneath it. When a handler finishes, the processor pulses the end-of-service input. This restores the level that was running before, so lower-ranked requests that were held off are then presented in turn. Vector lookup and saving of processor state are done outside this block.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After synchronous reset, `cur_level_o` is 0, and `irq_o` is low while no enabled source requests.
- R2: A source whose priority field is 0 never raises `irq_o` and never becomes the reported winner, even while its request is high.
- R3: The winner is the requesting source with the largest non-zero priority. On a tie, the lowest source index wins. With no enabled request, `win_id_o` is 0.
- R4: `irq_o` is high in the same cycle exactly when the winner's priority is strictly greater than `cur_level_o`. A request at the running level or below keeps `irq_o` low.
- R5: A cycle with `ack_i` high while `irq_o` is high sets `cur_level_o` to the winner's priority from the next cycle on.
- R6: `ack_i` while `irq_o` is low has no effect on `cur_level_o`.
- R7: `eos_i` restores `cur_level_o` to the level that was running before the latest acknowledge still in force. At level 0, `eos_i` is ignored.
- R8: When `ack_i` (with `irq_o` high) and `eos_i` arrive in the same cycle, the acknowledge is taken and the end-of-service is dropped.
- R9: Handlers can nest through all 15 levels (1, 2, ... 15). They unwind in reverse order, one level per end-of-service.
- R10: Requests are level-sensitive. A source that drops its request before it is acknowledged stops being considered in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | NUM_SRC | Level-sensitive request, one bit per source |
| prio_i | input | NUM_SRC*4 | Priority of source i in bits [4i+3:4i] |
| ack_i | input | 1 | Processor takes the presented interrupt |
| eos_i | input | 1 | Running handler has finished |
| irq_o | output | 1 | Interrupt line to the processor |
| win_id_o | output | ID_W | Index of the winning source |
| cur_level_o | output | 4 | Level of the running handler, 0 when none |

## Verification
`irq_o` and `win_id_o` are combinational from the requests, the priorities and the running level. The bench drives inputs at the falling edge and compares these outputs 1 ns later, in the same cycle. `cur_level_o` changes at the rising edge that samples `ack_i` or `eos_i`. The bench updates its model of the level stack at that edge and compares the level at the next falling edge, one cycle after the strobe. Directed cases cover ties, masking, stray strobes, simultaneous strobes and full 15-deep nesting. They are followed by seeded random traffic that is checked every cycle against the model.

// File: rtl/nic_pkg.sv
`timescale 1ns/1ps
package nic_pkg;

    localparam int PRIO_W  = 4;
    localparam int NUM_LVL = (1 << PRIO_W) - 1;

    typedef logic [PRIO_W-1:0]  prio_t;
    // one bit per level; bit k set means a handler at level k is in force
    typedef logic [NUM_LVL:1]   lvl_mask_t;

    typedef enum logic [1:0] {
        STK_HOLD = 2'd0,
        STK_PUSH = 2'd1,
        STK_POP  = 2'd2
    } stk_op_e;

    // highest level held in the mask, 0 when empty
    function automatic prio_t mask_top(input lvl_mask_t m);
        prio_t r;
        r = '0;
        for (int l = 1; l <= NUM_LVL; l++) begin
            if (m[l]) r = prio_t'(l);
        end
        return r;
    endfunction

    // mask with its highest level removed
    function automatic lvl_mask_t mask_drop_top(input lvl_mask_t m);
        lvl_mask_t r;
        prio_t     t;
        r = m;
        t = mask_top(m);
        for (int l = 1; l <= NUM_LVL; l++) begin
            if (prio_t'(l) == t) r[l] = 1'b0;
        end
        return r;
    endfunction

endpackage

// File: rtl/nic_arbiter.sv
`timescale 1ns/1ps
module nic_arbiter
    import nic_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int ID_W    = 3
) (
    input  logic [NUM_SRC-1:0]        req_i,
    input  logic [NUM_SRC*PRIO_W-1:0] prio_i,
    output logic                      win_valid_o,
    output prio_t                     win_lvl_o,
    output logic [ID_W-1:0]           win_id_o
);

    prio_t src_prio [NUM_SRC];

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_unpack
        assign src_prio[g] = req_i[g] ? prio_i[g*PRIO_W +: PRIO_W] : '0;
    end

    // strict compare keeps the lowest index on a tie; level 0 never beats 0
    always_comb begin
        win_lvl_o = '0;
        win_id_o  = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (src_prio[i] > win_lvl_o) begin
                win_lvl_o = src_prio[i];
                win_id_o  = ID_W'(i);
            end
        end
        win_valid_o = (win_lvl_o != '0);
    end

endmodule

// File: rtl/nic_gate.sv
`timescale 1ns/1ps
module nic_gate
    import nic_pkg::*;
(
    input  logic    win_valid_i,
    input  prio_t   win_lvl_i,
    input  prio_t   cur_lvl_i,
    input  logic    ack_i,
    input  logic    eos_i,
    output logic    irq_o,
    output stk_op_e op_o
);

    always_comb begin
        irq_o = win_valid_i && (win_lvl_i > cur_lvl_i);
        if (ack_i && irq_o) begin
            op_o = STK_PUSH;
        end else if (eos_i && (cur_lvl_i != '0)) begin
            op_o = STK_POP;
        end else begin
            op_o = STK_HOLD;
        end
    end

endmodule

// File: rtl/nic_level_stack.sv
`timescale 1ns/1ps
module nic_level_stack
    import nic_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  stk_op_e op_i,
    input  prio_t   push_lvl_i,
    output prio_t   cur_lvl_o
);

    // pushes are strictly increasing, so the stack is a set of levels
    lvl_mask_t active_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= '0;
        end else begin
            unique case (op_i)
                STK_PUSH: active_q <= active_q | (lvl_mask_t'(1) << (push_lvl_i - prio_t'(1)));
                STK_POP:  active_q <= mask_drop_top(active_q);
                default:  active_q <= active_q;
            endcase
        end
    end

    assign cur_lvl_o = mask_top(active_q);

endmodule

// File: rtl/nest_irq_ctrl.sv
`timescale 1ns/1ps
module nest_irq_ctrl
    import nic_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int ID_W    = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NUM_SRC-1:0]        req_i,
    input  logic [NUM_SRC*PRIO_W-1:0] prio_i,
    input  logic                      ack_i,
    input  logic                      eos_i,
    output logic                      irq_o,
    output logic [ID_W-1:0]           win_id_o,
    output logic [PRIO_W-1:0]         cur_level_o
);

    logic    win_valid;
    prio_t   win_lvl;
    prio_t   cur_lvl;
    stk_op_e stk_op;

    nic_arbiter #(
        .NUM_SRC (NUM_SRC),
        .ID_W    (ID_W)
    ) u_arb (
        .req_i       (req_i),
        .prio_i      (prio_i),
        .win_valid_o (win_valid),
        .win_lvl_o   (win_lvl),
        .win_id_o    (win_id_o)
    );

    nic_gate u_gate (
        .win_valid_i (win_valid),
        .win_lvl_i   (win_lvl),
        .cur_lvl_i   (cur_lvl),
        .ack_i       (ack_i),
        .eos_i       (eos_i),
        .irq_o       (irq_o),
        .op_o        (stk_op)
    );

    nic_level_stack u_stk (
        .clk        (clk),
        .rst        (rst),
        .op_i       (stk_op),
        .push_lvl_i (win_lvl),
        .cur_lvl_o  (cur_lvl)
    );

    assign cur_level_o = cur_lvl;

endmodule

// File: rtl/nic_checker.sv
`timescale 1ns/1ps
module nic_checker
    import nic_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int ID_W    = 3
) (
    input logic                      clk,
    input logic                      rst,
    input logic [NUM_SRC-1:0]        req_i,
    input logic [NUM_SRC*PRIO_W-1:0] prio_i,
    input logic                      ack_i,
    input logic                      eos_i,
    input logic                      irq_o,
    input logic [ID_W-1:0]           win_id_o,
    input logic [PRIO_W-1:0]         cur_level_o
);

    logic [PRIO_W-1:0] sel_prio;
    logic              sel_req;

    assign sel_prio = prio_i[int'(win_id_o)*PRIO_W +: PRIO_W];
    assign sel_req  = req_i[win_id_o];

    AST_WINNER_ENABLED: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (sel_req && (sel_prio != '0)));                              // R2

    AST_STRICTLY_ABOVE: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (sel_prio > cur_level_o));                                    // R4

    AST_ACK_LOADS: assert property (@(posedge clk) disable iff (rst)
        (ack_i && irq_o) |=> (cur_level_o == $past(sel_prio)));                 // R5

    AST_STRAY_ACK: assert property (@(posedge clk) disable iff (rst)
        (ack_i && !irq_o && !eos_i) |=> $stable(cur_level_o));                  // R6

    AST_EOS_UNWINDS: assert property (@(posedge clk) disable iff (rst)
        (eos_i && !(ack_i && irq_o) && (cur_level_o != '0))
            |=> (cur_level_o < $past(cur_level_o)));                            // R7

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!ack_i && !eos_i) |=> $stable(cur_level_o));                           // R7

    AST_ACK_OVER_EOS: assert property (@(posedge clk) disable iff (rst)
        (ack_i && eos_i && irq_o) |=> (cur_level_o > $past(cur_level_o)));      // R8

endmodule

bind nest_irq_ctrl nic_checker #(
    .NUM_SRC (NUM_SRC),
    .ID_W    (ID_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_i       (req_i),
    .prio_i      (prio_i),
    .ack_i       (ack_i),
    .eos_i       (eos_i),
    .irq_o       (irq_o),
    .win_id_o    (win_id_o),
    .cur_level_o (cur_level_o)
);

// File: tb/nest_irq_ctrl_tb.sv
`timescale 1ns/1ps
module nest_irq_ctrl_tb;

    localparam int N  = 8;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  req = '0;
    logic [3:0]    prio [N];
    logic [N*4-1:0] prio_flat;
    logic          ack = 1'b0;
    logic          eos = 1'b0;
    logic          irq;
    logic [IW-1:0] win_id;
    logic [3:0]    cur_level;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [15:1] m_mask;

    always #2.5 clk = ~clk;

    always_comb begin
        for (int i = 0; i < N; i++) prio_flat[i*4 +: 4] = prio[i];
    end

    nest_irq_ctrl #(.NUM_SRC(N)) u_dut (
        .clk         (clk),
        .rst         (rst),
        .req_i       (req),
        .prio_i      (prio_flat),
        .ack_i       (ack),
        .eos_i       (eos),
        .irq_o       (irq),
        .win_id_o    (win_id),
        .cur_level_o (cur_level)
    );

    function automatic int m_cur();
        int r = 0;
        for (int l = 1; l <= 15; l++) if (m_mask[l]) r = l;
        return r;
    endfunction

    function automatic int exp_lvl();
        int b = 0;
        for (int i = 0; i < N; i++) if (req[i] && int'(prio[i]) > b) b = int'(prio[i]);
        return b;
    endfunction

    function automatic int exp_id();
        int b = 0;
        int id = 0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && int'(prio[i]) > b) begin
                b  = int'(prio[i]);
                id = i;
            end
        end
        return id;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // called at a falling edge with inputs set; ends at the next falling edge
    task automatic cycle(input string tag);
        int  el;
        bit  ei;
        #1;
        el = exp_lvl();
        ei = (el > m_cur());
        check({tag, " irq"},   int'(irq),       int'(ei));
        check({tag, " id"},    int'(win_id),    exp_id());
        check({tag, " level"}, int'(cur_level), m_cur());
        @(posedge clk);
        if (ack && ei) begin
            m_mask[el] = 1'b1;
        end else if (eos && m_cur() != 0) begin
            m_mask[m_cur()] = 1'b0;
        end
        @(negedge clk);
    endtask

    task automatic clear_all();
        req = '0;
        ack = 1'b0;
        eos = 1'b0;
        for (int i = 0; i < N; i++) prio[i] = 4'd0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        clear_all();
        m_mask = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        check("R1 level", int'(cur_level), 0);
        check("R1 irq",   int'(irq),       0);

        // R2: priority 0 stays silent
        req = 8'b0000_1000;
        cycle("R2");
        check("R2 masked irq", int'(irq), 0);

        // R3: tie at level 5 between 2 and 6, lowest index wins
        prio[2] = 4'd5; prio[6] = 4'd5; prio[3] = 4'd0;
        req = 8'b0100_1100;
        #1;
        check("R3 tie id", int'(win_id), 2);
        @(negedge clk);

        // R5: acknowledge raises running level
        ack = 1'b1;
        cycle("R5");
        ack = 1'b0;
        check("R5 level after ack", int'(cur_level), 5);

        // R4: same and lower levels held off, higher preempts
        req = 8'b0100_0000;
        prio[4] = 4'd3; req[4] = 1'b1;
        cycle("R4 held");
        check("R4 same/lower irq", int'(irq), 0);
        prio[1] = 4'd9; req[1] = 1'b1;
        #1;
        check("R4 preempt irq", int'(irq), 1);
        check("R4 preempt id",  int'(win_id), 1);
        @(negedge clk);

        // R10: dropping the request removes it
        req[1] = 1'b0;
        #1;
        check("R10 dropped irq", int'(irq), 0);
        @(negedge clk);

        // R6: stray acknowledge
        ack = 1'b1;
        cycle("R6");
        ack = 1'b0;
        check("R6 level unchanged", int'(cur_level), 5);

        // R8: ack and eos together, ack taken
        req[1] = 1'b1;
        ack = 1'b1; eos = 1'b1;
        cycle("R8");
        ack = 1'b0; eos = 1'b0;
        check("R8 level", int'(cur_level), 9);

        // R7: unwind, then eos at level 0 ignored
        req = '0;
        eos = 1'b1;
        cycle("R7");
        check("R7 back to 5", int'(cur_level), 5);
        cycle("R7");
        check("R7 back to 0", int'(cur_level), 0);
        cycle("R7");
        check("R7 eos at 0", int'(cur_level), 0);
        eos = 1'b0;

        // R9: full nesting and reverse unwind
        clear_all();
        req = 8'b0000_0001;
        for (int k = 1; k <= 15; k++) begin
            prio[0] = 4'(k);
            ack = 1'b1;
            cycle("R9 push");
            check("R9 nested level", int'(cur_level), k);
        end
        ack = 1'b0;
        req = '0;
        for (int k = 15; k >= 1; k--) begin
            eos = 1'b1;
            cycle("R9 pop");
            check("R9 unwound level", int'(cur_level), k - 1);
        end
        eos = 1'b0;

        // random traffic checked every cycle against the model (R3 R4 R7)
        for (int c = 0; c < 3000; c++) begin
            if (($urandom % 8) == 0) begin
                for (int i = 0; i < N; i++) prio[i] = 4'($urandom % 16);
            end
            req = N'($urandom);
            ack = (($urandom % 3) == 0);
            eos = (($urandom % 4) == 0);
            cycle("R4 random");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule